// File: doc/BRIEF.md
# CAN Standard Frame Receiver and Field Checker

The block decodes base-format CAN data and remote frames (11-bit identifier) from one receive line that is already synchronous to the block clock. While the bus is idle it waits for a dominant level (logic 0). The clock cycle in which that level is first seen is the reference time for the whole frame. Each later bit is sampled at a fixed offset from that reference time. The bit period and the sample offset are inputs, given in clock cycles. The block applies no resynchronisation inside a frame.

Stuff bits are removed before bits are counted into fields. The block then extracts the identifier, the RTR bit, the data length code and the data bits, and records whether the ACK slot was driven dominant. The fixed-form parts of the frame are checked: start of frame, identifier range, DLC range, CRC delimiter, ACK delimiter and end of frame. Each violation is reported as a one-cycle pulse with its own 3-bit code. A frame-valid strobe marks the end of the end-of-frame field. The CRC value is not checked.

Top module: `can_frame_rx`

## Requirements
- R1: While idle (after reset and after each frame), the first clock cycle with `rx` = 0 starts a frame, and that cycle is time T0. While idle, `frm_vld` and `warn_vld` stay 0.
- R2: Raw bit n of a frame is sampled at T0 + n·`bit_len` + `samp_ofs`, with no resynchronisation. Valid settings are `bit_len` ≥ 2 and 1 ≤ `samp_ofs` < `bit_len`.
- R3: Stuff removal. Field bits 0 up to and including the last CRC bit are counted in runs of equal value. After 5 equal bits the next raw bit is a stuff bit and is discarded, and that stuff bit starts a new run of 1. A stuff bit may follow the last CRC bit. No bit after that point is discarded.
- R4: Field bit 0 is SOF. Field bits 1–11 form `frm_id`, first bit received as MSB. Field bit 12 is `frm_rtr`. Field bits 13–14 are ignored. Field bits 15–18 form `frm_dlc`, first bit received as MSB.
- R5: Let L = 18 + 8·min(DLC, 8). Field bits 19..L are the data. They appear right-aligned in `frm_data`, with the first data bit received as the most significant used bit and all unused upper bits 0.
- R6: Field bit L+17 is the ACK slot. `frm_ack` is 1 when it was sampled dominant.
- R7: `frm_vld` pulses for one cycle after field bit L+25, the last EOF bit. The frame outputs are valid in that cycle, and the block is idle in the next cycle.
- R8: A warning is a one-cycle `warn_vld` pulse with `warn_code`. The codes are: 1 SOF, 2 identifier, 3 DLC, 4 CRC delimiter, 5 ACK delimiter, 6 EOF.
- R9: Code 1 is raised when field bit 0 samples recessive (1).
- R10: Code 2 is raised when `frm_id` & 0x7F0 equals 0x7F0.
- R11: Code 3 is raised when DLC > 8. The frame is then decoded with 8 data bytes.
- R12: Code 4 is raised when field bit L+16 is dominant. Code 5 is raised when field bit L+18 is dominant.
- R13: Code 6 is raised once, together with `frm_vld`, when any of field bits L+19..L+25 was dominant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx | input | 1 | Synchronous receive line (0 = dominant) |
| bit_len | input | CNT_W | Bit period in clock cycles |
| samp_ofs | input | CNT_W | Sample point offset in clock cycles |
| frm_vld | output | 1 | Frame complete strobe |
| frm_id | output | 11 | Decoded identifier |
| frm_rtr | output | 1 | Decoded RTR bit |
| frm_dlc | output | 4 | Decoded data length code |
| frm_data | output | 8·MAX_BYTES | Data bits, right-aligned |
| frm_ack | output | 1 | ACK slot was dominant |
| warn_vld | output | 1 | Warning strobe |
| warn_code | output | 3 | Warning code |

## Verification
Clean frames with DLC 0 through 8 check that the data field length follows the DLC. Identifier and payload patterns with long runs of equal bits, plus a CRC ending in five ones, exercise stuff removal; any miscount there shifts every later field. One frame drives the complement of each bit for its first cycles, so it decodes correctly only if sampling happens at the configured offset. The fault frames each inject one field violation, which tells the six warning codes apart and shows that a fault in one field does not disturb the others.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;
   typedef enum logic [2:0] {
      WARN_NONE  = 3'd0,
      WARN_SOF   = 3'd1,
      WARN_ID    = 3'd2,
      WARN_DLC   = 3'd3,
      WARN_CRCD  = 3'd4,
      WARN_ACKD  = 3'd5,
      WARN_EOF   = 3'd6
   } warn_e;

   localparam int ID_W  = 11;
   localparam int DLC_W = 4;
endpackage

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             run,
   input  logic [CNT_W-1:0] bit_len,
   input  logic [CNT_W-1:0] samp_ofs,
   output logic             tick
);
   logic [CNT_W-1:0] ph;

   // ph holds the cycle offset inside the current bit, counted from T0
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ph <= '0;
      else if (start)
         ph <= CNT_W'(1);
      else if (run)
         ph <= (ph == bit_len - CNT_W'(1)) ? '0 : ph + CNT_W'(1);
   end

   assign tick = run && (ph == samp_ofs);
endmodule

// File: rtl/can_destuff.sv
module can_destuff #(
   parameter int RUN_LEN = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic tick,
   input  logic rx,
   input  logic cnt_en,
   output logic bit_vld,
   output logic bit_o
);
   localparam int RUN_W = $clog2(RUN_LEN + 1);

   logic [RUN_W-1:0] run;
   logic             prev;
   logic             is_stuff;

   assign is_stuff = (run == RUN_W'(RUN_LEN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run  <= '0;
         prev <= 1'b1;
      end else if (start) begin
         run  <= '0;
         prev <= 1'b1;
      end else if (tick) begin
         if (is_stuff) begin
            run  <= RUN_W'(1);
            prev <= rx;
         end else if (cnt_en) begin
            run  <= (run != '0 && rx == prev) ? run + RUN_W'(1) : RUN_W'(1);
            prev <= rx;
         end else begin
            run <= '0;
         end
      end
   end

   assign bit_vld = tick && !is_stuff;
   assign bit_o   = rx;
endmodule

// File: rtl/can_field_parse.sv
module can_field_parse
   import can_rx_pkg::*;
#(
   parameter int MAX_BYTES = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic                   bit_vld,
   input  logic                   bit_i,
   output logic                   cnt_en,
   output logic                   frm_vld,
   output logic [ID_W-1:0]        frm_id,
   output logic                   frm_rtr,
   output logic [DLC_W-1:0]       frm_dlc,
   output logic [8*MAX_BYTES-1:0] frm_data,
   output logic                   frm_ack,
   output logic                   warn_vld,
   output logic [2:0]             warn_code
);
   localparam int DATA_W   = 8 * MAX_BYTES;
   localparam int LAST_MAX = 18 + DATA_W + 25;
   localparam int POS_W    = $clog2(LAST_MAX + 1);

   logic [POS_W-1:0] pos, last_p;
   logic             eof_bad;
   logic [ID_W-1:0]  id_nx;
   logic [DLC_W-1:0] dlc_nx;
   logic [POS_W-1:0] last_nx;
   logic             w_hit, eof_end;
   warn_e            w_code;

   assign id_nx  = {frm_id[ID_W-2:0], bit_i};
   assign dlc_nx = {frm_dlc[DLC_W-2:0], bit_i};
   assign last_nx = POS_W'(18) + ((dlc_nx > DLC_W'(MAX_BYTES)) ?
                    POS_W'(DATA_W) : POS_W'({dlc_nx, 3'b000}));
   assign cnt_en  = (pos <= last_p + POS_W'(15));
   assign eof_end = (pos == last_p + POS_W'(25));

   always_comb begin
      w_hit  = 1'b0;
      w_code = WARN_NONE;
      if (pos == '0 && bit_i) begin
         w_hit = 1'b1; w_code = WARN_SOF;
      end else if (pos == POS_W'(11) && (id_nx & 11'h7F0) == 11'h7F0) begin
         w_hit = 1'b1; w_code = WARN_ID;
      end else if (pos == POS_W'(18) && dlc_nx > DLC_W'(8)) begin
         w_hit = 1'b1; w_code = WARN_DLC;
      end else if (pos == last_p + POS_W'(16) && !bit_i) begin
         w_hit = 1'b1; w_code = WARN_CRCD;
      end else if (pos == last_p + POS_W'(18) && !bit_i) begin
         w_hit = 1'b1; w_code = WARN_ACKD;
      end else if (eof_end && (eof_bad || !bit_i)) begin
         w_hit = 1'b1; w_code = WARN_EOF;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos <= '0; last_p <= POS_W'(18); eof_bad <= 1'b0;
         frm_id <= '0; frm_rtr <= 1'b0; frm_dlc <= '0; frm_data <= '0;
         frm_ack <= 1'b0; frm_vld <= 1'b0; warn_vld <= 1'b0; warn_code <= '0;
      end else if (start) begin
         pos <= '0; last_p <= POS_W'(18); eof_bad <= 1'b0;
         frm_id <= '0; frm_rtr <= 1'b0; frm_dlc <= '0; frm_data <= '0;
         frm_ack <= 1'b0; frm_vld <= 1'b0; warn_vld <= 1'b0; warn_code <= '0;
      end else begin
         frm_vld  <= 1'b0;
         warn_vld <= 1'b0;
         if (bit_vld) begin
            pos       <= pos + POS_W'(1);
            warn_vld  <= w_hit;
            warn_code <= w_code;
            if (pos >= POS_W'(1) && pos <= POS_W'(11))
               frm_id <= id_nx;
            if (pos == POS_W'(12))
               frm_rtr <= bit_i;
            if (pos >= POS_W'(15) && pos <= POS_W'(18))
               frm_dlc <= dlc_nx;
            if (pos == POS_W'(18))
               last_p <= last_nx;
            if (pos >= POS_W'(19) && pos <= last_p)
               frm_data <= {frm_data[DATA_W-2:0], bit_i};
            if (pos == last_p + POS_W'(17))
               frm_ack <= !bit_i;
            if (pos >= last_p + POS_W'(19) && !bit_i)
               eof_bad <= 1'b1;
            if (eof_end)
               frm_vld <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/can_frame_rx.sv
module can_frame_rx
   import can_rx_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int MAX_BYTES = 8,
   parameter int RUN_LEN   = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   rx,
   input  logic [CNT_W-1:0]       bit_len,
   input  logic [CNT_W-1:0]       samp_ofs,
   output logic                   frm_vld,
   output logic [ID_W-1:0]        frm_id,
   output logic                   frm_rtr,
   output logic [DLC_W-1:0]       frm_dlc,
   output logic [8*MAX_BYTES-1:0] frm_data,
   output logic                   frm_ack,
   output logic                   warn_vld,
   output logic [2:0]             warn_code
);
   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must be at least 2");
      end
      if (MAX_BYTES < 1 || MAX_BYTES > 8) begin : g_bad_bytes
         $error("MAX_BYTES must lie in 1..8");
      end
      if (RUN_LEN < 2) begin : g_bad_run
         $error("RUN_LEN must be at least 2");
      end
   endgenerate

   logic busy, start, tick, cnt_en, db_vld, db;

   assign start = !busy && !rx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       busy <= 1'b0;
      else if (start)   busy <= 1'b1;
      else if (frm_vld) busy <= 1'b0;
   end

   can_bit_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(start), .run(busy),
      .bit_len(bit_len), .samp_ofs(samp_ofs), .tick(tick)
   );

   can_destuff #(.RUN_LEN(RUN_LEN)) u_destuff (
      .clk(clk), .rst_n(rst_n), .start(start), .tick(tick), .rx(rx),
      .cnt_en(cnt_en), .bit_vld(db_vld), .bit_o(db)
   );

   can_field_parse #(.MAX_BYTES(MAX_BYTES)) u_parse (
      .clk(clk), .rst_n(rst_n), .start(start), .bit_vld(db_vld), .bit_i(db),
      .cnt_en(cnt_en), .frm_vld(frm_vld), .frm_id(frm_id), .frm_rtr(frm_rtr),
      .frm_dlc(frm_dlc), .frm_data(frm_data), .frm_ack(frm_ack),
      .warn_vld(warn_vld), .warn_code(warn_code)
   );
endmodule

// File: rtl/can_frame_rx_chk.sv
module can_frame_rx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rx,
   input logic       busy,
   input logic       frm_vld,
   input logic       warn_vld,
   input logic [2:0] warn_code
);
   assert_sof_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !rx) |=> busy);

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!frm_vld && !warn_vld));

   assert_vld_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      frm_vld |=> !frm_vld);

   assert_end_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      frm_vld |=> !busy);

   assert_warn_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
      warn_vld |-> (warn_code >= 3'd1 && warn_code <= 3'd6));

   assert_warn_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      warn_vld |=> !warn_vld);
endmodule

bind can_frame_rx can_frame_rx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .rx(rx), .busy(busy),
   .frm_vld(frm_vld), .warn_vld(warn_vld), .warn_code(warn_code)
);

// File: tb/can_frame_rx_tb.sv
module can_frame_rx_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx = 1'b1;
   logic [15:0] bit_len = 16'd8;
   logic [15:0] samp_ofs = 16'd5;
   logic        frm_vld, frm_rtr, frm_ack, warn_vld;
   logic [10:0] frm_id;
   logic [3:0]  frm_dlc;
   logic [63:0] frm_data;
   logic [2:0]  warn_code;

   int checks = 0;
   int fails  = 0;

   logic [7:0]  wseen;
   logic        got;
   logic [10:0] c_id;
   logic        c_rtr, c_ack;
   logic [3:0]  c_dlc;
   logic [63:0] c_data;

   always #10 clk = ~clk;

   can_frame_rx u_dut (
      .clk(clk), .rst_n(rst_n), .rx(rx), .bit_len(bit_len), .samp_ofs(samp_ofs),
      .frm_vld(frm_vld), .frm_id(frm_id), .frm_rtr(frm_rtr), .frm_dlc(frm_dlc),
      .frm_data(frm_data), .frm_ack(frm_ack), .warn_vld(warn_vld), .warn_code(warn_code)
   );

   always @(negedge clk) begin
      if (warn_vld) wseen[warn_code] = 1'b1;
      if (frm_vld) begin
         got = 1'b1; c_id = frm_id; c_rtr = frm_rtr; c_dlc = frm_dlc;
         c_data = frm_data; c_ack = frm_ack;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // fault: 0 none,1 SOF glitch,2 CRC delim,3 ACK delim,4 EOF bit; corr: cycles of complemented level per bit
   task automatic send(input logic [10:0] id, input logic rtr, input logic [3:0] dlc,
                       input logic [63:0] data, input logic [14:0] crc, input logic ack_dom,
                       input int fault, input int corr);
      logic fb[0:127];
      logic sb[0:159];
      int   nd, last, nf, ns, run;
      logic prev;
      nd   = 8 * ((dlc > 8) ? 8 : int'(dlc));
      last = 18 + nd;
      fb[0] = (fault == 1);
      for (int i = 0; i < 11; i++) fb[1+i] = id[10-i];
      fb[12] = rtr; fb[13] = 1'b0; fb[14] = 1'b0;
      for (int i = 0; i < 4; i++) fb[15+i] = dlc[3-i];
      for (int i = 0; i < nd; i++) fb[19+i] = data[nd-1-i];
      for (int i = 0; i < 15; i++) fb[last+1+i] = crc[14-i];
      fb[last+16] = (fault != 2);
      fb[last+17] = !ack_dom;
      fb[last+18] = (fault != 3);
      for (int i = 0; i < 7; i++) fb[last+19+i] = !(fault == 4 && i == 3);
      nf = last + 26;
      ns = 0; run = 0; prev = 1'b1;
      for (int i = 0; i < nf; i++) begin
         sb[ns] = fb[i]; ns++;
         if (i <= last + 15) begin
            run  = (run != 0 && fb[i] == prev) ? run + 1 : 1;
            prev = fb[i];
            if (run == 5) begin
               sb[ns] = !prev; ns++; prev = !prev; run = 1;
            end
         end else run = 0;
      end
      wseen = '0; got = 1'b0;
      for (int k = 0; k < ns; k++)
         for (int c = 0; c < int'(bit_len); c++) begin
            if (k == 0) rx = (fault == 1 && c >= 2) ? 1'b1 : 1'b0;
            else        rx = (c < corr) ? !sb[k] : sb[k];
            @(negedge clk);
         end
      rx = 1'b1;
      repeat (3 * int'(bit_len)) @(negedge clk);
   endtask

   task automatic clean_frame(input logic [10:0] id, input logic rtr, input logic [3:0] dlc,
                              input logic [63:0] data, input logic [14:0] crc, input logic ackd);
      int nd;
      logic [63:0] exp;
      nd  = 8 * ((dlc > 8) ? 8 : int'(dlc));
      exp = (nd == 64) ? data : (data & ((64'd1 << nd) - 64'd1));
      send(id, rtr, dlc, data, crc, ackd, 0, 0);
      chk("R7 frame strobe", 64'(got), 64'd1);
      chk("R4 identifier", 64'(c_id), 64'(id));
      chk("R4 rtr", 64'(c_rtr), 64'(rtr));
      chk("R4 dlc", 64'(c_dlc), 64'(dlc));
      chk("R5 data", c_data, exp);
      chk("R6 ack", 64'(c_ack), 64'(ackd));
      chk("R3 R8 no warning on clean frame", 64'(wseen), 64'd0);
   endtask

   task automatic fault_frame(input string tag, input logic [10:0] id, input logic [3:0] dlc,
                              input int fault, input int code);
      logic [7:0] ew;
      ew = '0; ew[code] = 1'b1;
      send(id, 1'b0, dlc, 64'hA5C3_0F96_1E2D_3C4B, 15'h2B6D, 1'b1, fault, 0);
      chk({tag, " warning code"}, 64'(wseen), 64'(ew));
      chk({tag, " frame still ends"}, 64'(got), 64'd1);
      chk({tag, " id intact"}, 64'(c_id), 64'(id));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      wseen = '0; got = 1'b0;
      repeat (4) @(negedge clk);
      chk("R1 reset frm_vld", 64'(frm_vld), 64'd0);
      chk("R1 reset warn_vld", 64'(warn_vld), 64'd0);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      chk("R1 idle stays quiet", 64'(wseen) | 64'(got), 64'd0);

      // DLC sweep; id 0 and all-ones bytes give long equal runs (R3)
      for (int d = 0; d <= 8; d++)
         clean_frame(11'(d * 157), d[0], 4'(d), 64'h1122_3344_5566_7788, 15'h4A53, d[1]);
      clean_frame(11'h000, 1'b0, 4'd8, 64'hFFFF_FFFF_0000_0000, 15'h001F, 1'b1); // R3 stuff after CRC
      clean_frame(11'h7EF, 1'b1, 4'd2, 64'h0000_0000_0000_FF00, 15'h7FE0, 1'b0);

      // R2: first 6 cycles of each bit inverted; only a sample at offset 9 decodes it
      bit_len = 16'd12; samp_ofs = 16'd9;
      send(11'h3A5, 1'b0, 4'd3, 64'h0000_0000_00C3_5A81, 15'h1234, 1'b1, 0, 6);
      chk("R2 sample point id", 64'(c_id), 64'h3A5);
      chk("R2 sample point data", c_data, 64'hC35A81);
      chk("R2 sample point no warning", 64'(wseen), 64'd0);
      bit_len = 16'd8; samp_ofs = 16'd5;

      fault_frame("R9 sof", 11'h155, 4'd2, 1, 1);
      fault_frame("R10 id", 11'h7F5, 4'd1, 0, 2);
      fault_frame("R11 dlc", 11'h123, 4'd12, 0, 3);
      chk("R11 data as 8 bytes", c_data, 64'hA5C3_0F96_1E2D_3C4B);
      chk("R11 dlc kept", 64'(c_dlc), 64'd12);
      fault_frame("R12 crc delimiter", 11'h2AA, 4'd1, 2, 4);
      fault_frame("R12 ack delimiter", 11'h0F0, 4'd4, 3, 5);
      fault_frame("R13 eof", 11'h321, 4'd0, 4, 6);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule